// File: doc/BRIEF.md
# EPROM Byte Programming Sequencer

This block writes one byte at a time into a UV-erasable parallel EPROM and then reads it back to confirm it. It drives enables for the raised core supply and the programming supply, the 15-bit address, the 8-bit write data with its tri-state enable, and the active-low chip-enable and output-enable strobes. All microsecond and nanosecond intervals are derived from a clock-rate parameter. A single shared countdown timer times every interval.

A byte job begins when `req` is sampled high while the block is idle. If the supplies are off, the block first raises them in a safe order. It places the address and data on the bus and applies a programming pulse on chip enable. After a data hold interval it releases the data bus and performs a verify read under output enable. It then waits for the part's outputs to float and compares the read byte with the target byte. On a mismatch it repeats the pulse and verify cycle, up to a retry limit. It reports the result with a one-cycle `done` strobe and a held `pass` flag. The supplies stay raised between bytes and are lowered only by an explicit power-down request made while idle.

Top module: `eprom_prog_seq`

## Requirements
- R1: The core-supply enable rises at least SETUP_CYC cycles before the programming-supply enable rises. The programming-supply enable falls at least SETUP_CYC cycles before the core-supply enable falls. The programming-supply enable is never high while the core-supply enable is low.
- R2: Before chip enable falls, address and data are driven with `rom_d_oe` high and both strobes high for at least SETUP_CYC cycles (SETUP_CYC = SETUP_US × CLK_MHZ).
- R3: `rom_ce_n` stays low for exactly PULSE_CYC = PULSE_US × CLK_MHZ cycles. During that time `rom_oe_n` is high, the programming supply is on, and the address and data are stable.
- R4: After `rom_ce_n` rises, address and data stay driven with `rom_d_oe` high for at least HOLD_CYC cycles.
- R5: `rom_oe_n` and `rom_d_oe` are never active together. `rom_oe_n` falls at least SETUP_CYC cycles after `rom_d_oe` falls.
- R6: `rom_oe_n` stays low for exactly ACC_CYC = ceil(ACC_NS × CLK_MHZ / 1000) cycles, and `rom_q` is sampled in the last of them. After a verify, `rom_d_oe` rises again no sooner than FLOAT_CYC = ceil(FLOAT_NS × CLK_MHZ / 1000) cycles after `rom_oe_n` rises.
- R7: A verify read equal to the target byte ends the job with `pass` = 1. With the supplies already on, this happens k × (2·SETUP_CYC + PULSE_CYC + HOLD_CYC + ACC_CYC + FLOAT_CYC + 1) cycles after the request edge, where k is the number of pulses used. Another 2·SETUP_CYC cycles are added when the supplies had to be raised first.
- R8: On a mismatch the pulse and verify cycle repeats. After 1 + MAX_RETRIES pulses that all fail, the job ends with `pass` = 0, and no further pulse is applied.
- R9: `done` is high for exactly one cycle per job. `pass` holds its value until the next accepted request. `req` has no effect while a job is in progress.
- R10: `pwr_down` has no effect while a job is in progress. When it is seen while the block is idle, the programming supply is lowered first and the core supply SETUP_CYC cycles later, and then the block returns to idle.
- R11: After reset both strobes are high, `rom_d_oe`, both supply enables, `busy`, `done` and `pass` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start a byte job (sampled when idle) |
| req_addr | input | 15 | Target byte address |
| req_data | input | 8 | Target byte value |
| pwr_down | input | 1 | Lower both supplies (sampled when idle) |
| rom_q | input | 8 | Byte read from the EPROM data pins |
| busy | output | 1 | Job or power-down in progress |
| done | output | 1 | One-cycle end-of-job strobe |
| pass | output | 1 | Result of the last job, 1 = verified |
| vcc_hi_en | output | 1 | Raise core supply to programming level |
| vpp_hi_en | output | 1 | Raise programming supply |
| rom_addr | output | 15 | EPROM address |
| rom_d | output | 8 | Write data to the EPROM |
| rom_d_oe | output | 1 | Drive enable for `rom_d` |
| rom_ce_n | output | 1 | Chip enable, active low (programming pulse) |
| rom_oe_n | output | 1 | Output enable, active low (verify read) |

## Verification
The result of a job is due at a fixed number of cycles after the request edge. That count is one attempt length times the number of pulses, plus the power-up time when the supplies were off. The bench computes this count from the parameters and the pulse need it assigned to the byte model, then counts falling edges until `done` and compares the totals. The interval checks are done by cycle counters that sample on the falling clock edge: setup, pulse width, hold, bus turnaround, access and float. Each counter is checked on the cycle its closing strobe edge is seen, so the value compared is the width of the interval that just ended.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PWR_UP,
    S_ADDR_DATA_SETUP,
    S_PULSE,
    S_HOLD,
    S_VERIFY_SETUP,
    S_VERIFY_READ,
    S_FLOAT,
    S_COMPARE,
    S_DONE,
    S_PWR_DN
  } seq_state_t;

  function automatic int us_to_cyc(input int us, input int mhz);
    int c;
    c = us * mhz;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int ns_to_cyc(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/prog_retry_ctr.sv
module prog_retry_ctr #(
  parameter int MAX_RETRIES = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic bump,
  output logic exhausted
);

  localparam int CW = $clog2(MAX_RETRIES + 2);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_RETRIES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (bump && cnt != LIMIT) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign exhausted = (cnt == LIMIT);

  AST_RETRY_NOT_PAST_LIMIT: assert property (@(posedge clk) disable iff (rst)
    bump |-> !exhausted); // R8

endmodule

// File: rtl/prog_verify_cmp.sv
module prog_verify_cmp #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [DW-1:0] rd_byte,
  input  logic [DW-1:0] want,
  output logic          match
);

  logic [DW-1:0] got;

  always_ff @(posedge clk) begin
    if (rst) begin
      got <= '0;
    end else if (capture) begin
      got <= rd_byte;
    end
  end

  assign match = (got == want);

endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
  import eprom_prog_pkg::*;
#(
  parameter int AW          = 15,
  parameter int DW          = 8,
  parameter int CLK_MHZ     = 100,
  parameter int SETUP_US    = 2,
  parameter int PULSE_US    = 100,
  parameter int HOLD_US     = 2,
  parameter int ACC_NS      = 100,
  parameter int FLOAT_NS    = 130,
  parameter int MAX_RETRIES = 25
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          pwr_down,
  input  logic [DW-1:0] rom_q,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          vcc_hi_en,
  output logic          vpp_hi_en,
  output logic [AW-1:0] rom_addr,
  output logic [DW-1:0] rom_d,
  output logic          rom_d_oe,
  output logic          rom_ce_n,
  output logic          rom_oe_n
);

  localparam int SETUP_CYC = us_to_cyc(SETUP_US, CLK_MHZ);
  localparam int PULSE_CYC = us_to_cyc(PULSE_US, CLK_MHZ);
  localparam int HOLD_CYC  = us_to_cyc(HOLD_US, CLK_MHZ);
  localparam int ACC_CYC   = ns_to_cyc(ACC_NS, CLK_MHZ);
  localparam int FLOAT_CYC = ns_to_cyc(FLOAT_NS, CLK_MHZ);
  localparam int MAX_CYC   = max2(max2(max2(SETUP_CYC, PULSE_CYC), max2(HOLD_CYC, ACC_CYC)), FLOAT_CYC);
  localparam int TW        = $clog2(MAX_CYC + 1);

  localparam logic [TW-1:0] LD_SETUP = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] LD_PULSE = TW'(PULSE_CYC - 1);
  localparam logic [TW-1:0] LD_HOLD  = TW'(HOLD_CYC - 1);
  localparam logic [TW-1:0] LD_ACC   = TW'(ACC_CYC - 1);
  localparam logic [TW-1:0] LD_FLOAT = TW'(FLOAT_CYC - 1);

  seq_state_t    state, nxt;
  logic          t_load, t_exp;
  logic [TW-1:0] t_val;
  logic          r_clear, r_bump, r_exhausted;
  logic          v_cap, v_match;

  prog_timer #(.W(TW)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_exp)
  );

  prog_retry_ctr #(.MAX_RETRIES(MAX_RETRIES)) i_retry (
    .clk       (clk),
    .rst       (rst),
    .clear     (r_clear),
    .bump      (r_bump),
    .exhausted (r_exhausted)
  );

  prog_verify_cmp #(.DW(DW)) i_cmp (
    .clk     (clk),
    .rst     (rst),
    .capture (v_cap),
    .rd_byte (rom_q),
    .want    (rom_d),
    .match   (v_match)
  );

  // Next state and timer control
  always_comb begin
    nxt     = state;
    t_load  = 1'b0;
    t_val   = '0;
    r_clear = 1'b0;
    r_bump  = 1'b0;
    v_cap   = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (req) begin
          r_clear = 1'b1;
          t_load  = 1'b1;
          t_val   = LD_SETUP;
          nxt     = vpp_hi_en ? S_ADDR_DATA_SETUP : S_PWR_UP;
        end else if (pwr_down && vcc_hi_en) begin
          t_load = 1'b1;
          t_val  = LD_SETUP;
          nxt    = S_PWR_DN;
        end
      end
      S_PWR_UP: if (t_exp) begin
        t_load = 1'b1;
        t_val  = LD_SETUP;
        nxt    = vpp_hi_en ? S_ADDR_DATA_SETUP : S_PWR_UP;
      end
      S_ADDR_DATA_SETUP: if (t_exp) begin
        t_load = 1'b1;
        t_val  = LD_PULSE;
        nxt    = S_PULSE;
      end
      S_PULSE: if (t_exp) begin
        t_load = 1'b1;
        t_val  = LD_HOLD;
        nxt    = S_HOLD;
      end
      S_HOLD: if (t_exp) begin
        t_load = 1'b1;
        t_val  = LD_SETUP;
        nxt    = S_VERIFY_SETUP;
      end
      S_VERIFY_SETUP: if (t_exp) begin
        t_load = 1'b1;
        t_val  = LD_ACC;
        nxt    = S_VERIFY_READ;
      end
      S_VERIFY_READ: if (t_exp) begin
        v_cap  = 1'b1;
        t_load = 1'b1;
        t_val  = LD_FLOAT;
        nxt    = S_FLOAT;
      end
      S_FLOAT: if (t_exp) nxt = S_COMPARE;
      S_COMPARE: begin
        if (v_match || r_exhausted) begin
          nxt = S_DONE;
        end else begin
          r_bump = 1'b1;
          t_load = 1'b1;
          t_val  = LD_SETUP;
          nxt    = S_ADDR_DATA_SETUP;
        end
      end
      S_DONE:   nxt = S_IDLE;
      S_PWR_DN: if (t_exp) nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  // Registered outputs, decoded from the state being entered
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      pass      <= 1'b0;
      vcc_hi_en <= 1'b0;
      vpp_hi_en <= 1'b0;
      rom_addr  <= '0;
      rom_d     <= '0;
      rom_d_oe  <= 1'b0;
      rom_ce_n  <= 1'b1;
      rom_oe_n  <= 1'b1;
    end else begin
      state    <= nxt;
      busy     <= (nxt != S_IDLE);
      done     <= (nxt == S_DONE);
      rom_ce_n <= (nxt != S_PULSE);
      rom_oe_n <= (nxt != S_VERIFY_READ);
      rom_d_oe <= (nxt == S_ADDR_DATA_SETUP) || (nxt == S_PULSE) || (nxt == S_HOLD);
      if (state == S_IDLE && req) begin
        rom_addr <= req_addr;
        rom_d    <= req_data;
        pass     <= 1'b0;
      end
      if (state == S_COMPARE && nxt == S_DONE) pass <= v_match;
      if (state == S_IDLE && nxt == S_PWR_UP) vcc_hi_en <= 1'b1;
      if (state == S_PWR_UP && t_exp && !vpp_hi_en) vpp_hi_en <= 1'b1;
      if (state == S_IDLE && nxt == S_PWR_DN) vpp_hi_en <= 1'b0;
      if (state == S_PWR_DN && nxt == S_IDLE) vcc_hi_en <= 1'b0;
    end
  end

  AST_VPP_NEEDS_VCC: assert property (@(posedge clk) disable iff (rst)
    vpp_hi_en |-> vcc_hi_en); // R1

  AST_VPP_RISE_AFTER_VCC: assert property (@(posedge clk) disable iff (rst)
    $rose(vpp_hi_en) |-> $past(vcc_hi_en)); // R1

  AST_PULSE_CONDITIONS: assert property (@(posedge clk) disable iff (rst)
    !rom_ce_n |-> (vpp_hi_en && rom_oe_n && rom_d_oe)); // R3

  AST_PULSE_BUS_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!rom_ce_n && $past(!rom_ce_n)) |-> ($stable(rom_addr) && $stable(rom_d))); // R3

  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (rst)
    !rom_oe_n |-> !rom_d_oe); // R5

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_SUPPLY_FALL_ONLY_IDLE_REQ: assert property (@(posedge clk) disable iff (rst)
    $fell(vpp_hi_en) |-> $past(pwr_down) && !done); // R10

endmodule

// File: tb/test_eprom_prog_seq.sv
module test_eprom_prog_seq;

  localparam int AW = 15, DW = 8, MHZ = 10, MAXR = 3;
  localparam int S = 2 * MHZ, P = 100 * MHZ, H = 2 * MHZ;
  localparam int A = (100 * MHZ + 999) / 1000;
  localparam int F = (130 * MHZ + 999) / 1000;

  logic clk = 1'b0, rst = 1'b1, req = 1'b0, pwr_down = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [DW-1:0] rom_q;
  logic busy, done, pass, vcc, vpp, d_oe, ce_n, oe_n;
  logic [AW-1:0] rom_addr;
  logic [DW-1:0] rom_d;

  int n_run = 0, n_fail = 0, cyc = 0;
  int need = 1, pulses_seen = 0;
  logic [AW-1:0] cur_addr = '0;
  logic [DW-1:0] cur_data = '0;

  always #5 clk = ~clk;

  eprom_prog_seq #(.AW(AW), .DW(DW), .CLK_MHZ(MHZ), .MAX_RETRIES(MAXR)) i_eprom_prog_seq (
    .clk(clk), .rst(rst), .req(req), .req_addr(req_addr), .req_data(req_data),
    .pwr_down(pwr_down), .rom_q(rom_q), .busy(busy), .done(done), .pass(pass),
    .vcc_hi_en(vcc), .vpp_hi_en(vpp), .rom_addr(rom_addr), .rom_d(rom_d),
    .rom_d_oe(d_oe), .rom_ce_n(ce_n), .rom_oe_n(oe_n)
  );

  // EPROM model: a byte reads back correctly once it has had 'need' pulses
  always_comb rom_q = !oe_n ? ((pulses_seen >= need) ? cur_data : ~cur_data) : 8'h00;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int exp_pulses(input int nd);
    return (nd <= MAXR + 1) ? nd : MAXR + 1;
  endfunction
  function automatic int exp_latency(input int nd, input bit pwr_on);
    return exp_pulses(nd) * (2 * S + P + H + A + F + 1) + (pwr_on ? 0 : 2 * S);
  endfunction

  // Interval monitors, sampled on the falling edge
  logic p_vcc = 0, p_vpp = 0, p_ce = 1, p_oe = 1, p_doe = 0;
  int vcc_on_at = 0, vpp_off_at = 0, doe_off_at = 0, oe_off_at = -1000;
  int setup_run = 0, pulse_run = 0, hold_run = 0, oe_run = 0;
  bit in_hold = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (vpp && !vcc) chk(0, "R1 vpp without vcc", 1, 0);
      if (vcc && !p_vcc) vcc_on_at = cyc;
      if (vpp && !p_vpp) chk(cyc - vcc_on_at >= S, "R1 vcc-to-vpp rise gap", cyc - vcc_on_at, S);
      if (!vpp && p_vpp) vpp_off_at = cyc;
      if (!vcc && p_vcc) chk(cyc - vpp_off_at >= S, "R1 vpp-to-vcc fall gap", cyc - vpp_off_at, S);
      // R2
      if (!ce_n && p_ce) chk(setup_run >= S, "R2 setup before pulse", setup_run, S);
      if (d_oe && ce_n && oe_n && rom_addr == cur_addr && rom_d == cur_data) setup_run++;
      else setup_run = 0;
      // R3
      if (!ce_n) begin
        pulse_run++;
        if (!oe_n || !vpp || rom_addr != cur_addr || rom_d != cur_data)
          chk(0, "R3 pulse conditions", 0, 1);
      end
      if (ce_n && !p_ce) begin
        chk(pulse_run == P, "R3 pulse width", pulse_run, P);
        pulse_run = 0;
        pulses_seen++;
        in_hold = 1;
        hold_run = 0;
      end
      // R4
      if (in_hold) begin
        if (d_oe && rom_d == cur_data && rom_addr == cur_addr) hold_run++;
        else begin
          chk(hold_run >= H, "R4 hold after pulse", hold_run, H);
          in_hold = 0;
        end
      end
      // R5
      if (!oe_n && d_oe) chk(0, "R5 bus fight", 1, 0);
      if (!d_oe && p_doe) doe_off_at = cyc;
      if (!oe_n && p_oe) chk(cyc - doe_off_at >= S, "R5 turnaround", cyc - doe_off_at, S);
      // R6
      if (!oe_n) oe_run++;
      if (oe_n && !p_oe) begin
        chk(oe_run == A, "R6 access window", oe_run, A);
        oe_run = 0;
        oe_off_at = cyc;
      end
      if (d_oe && !p_doe && cyc - oe_off_at < 100)
        chk(cyc - oe_off_at >= F, "R6 float before redrive", cyc - oe_off_at, F);
    end
    p_vcc = vcc; p_vpp = vpp; p_ce = ce_n; p_oe = oe_n; p_doe = d_oe;
  end

  task automatic run_byte(input logic [AW-1:0] a, input logic [DW-1:0] d, input int nd);
    int t;
    bit pwr_on;
    bit exp_ok;
    pwr_on = vpp;
    exp_ok = (nd <= MAXR + 1);
    @(negedge clk);
    cur_addr = a; cur_data = d; need = nd; pulses_seen = 0;
    req = 1'b1; req_addr = a; req_data = d;
    @(negedge clk);
    req = 1'b0;
    t = 0;
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
      if (t == 50) begin  // R9, R10: request and power-down while busy
        req = 1'b1; req_addr = ~a; req_data = ~d; pwr_down = 1'b1;
      end
      if (t == 51) begin
        req = 1'b0; pwr_down = 1'b0;
      end
    end
    chk(t == exp_latency(nd, pwr_on), "R7 done latency", t, exp_latency(nd, pwr_on));
    chk(pass == exp_ok, exp_ok ? "R7 pass" : "R8 fail flag", pass, exp_ok);
    chk(pulses_seen == exp_pulses(nd), "R8 pulse count", pulses_seen, exp_pulses(nd));
    chk(vpp && vcc, "R10 supplies kept during job", {vcc, vpp}, 3);
    @(negedge clk);
    chk(!done, "R9 done one cycle", done, 0);
    repeat (3) @(negedge clk);
    chk(pass == exp_ok && !busy, "R9 pass held", pass, exp_ok);
  endtask

  initial begin
    #2_000_000;
    chk(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ce_n && oe_n && !d_oe && !vcc && !vpp && !busy && !done && !pass,
        "R11 reset state", {ce_n, oe_n, d_oe, vcc, vpp, busy, done, pass}, 8'b11000000);

    run_byte(15'h1234, 8'hA5, 1);          // power-up path, R1 R7
    run_byte(15'h7FFF, 8'h00, MAXR + 1);   // passes on last allowed pulse, R8
    run_byte(15'h0000, 8'h3C, MAXR + 2);   // never verifies, R8
    for (int i = 0; i < 5; i++)
      run_byte(AW'($urandom), DW'($urandom), 1 + int'($urandom % 3));

    // R10: power-down from idle
    @(negedge clk);
    pwr_down = 1'b1;
    @(negedge clk);
    pwr_down = 1'b0;
    chk(!vpp && vcc && busy, "R10 vpp lowered first", {vcc, vpp}, 2);
    repeat (S + 2) @(negedge clk);
    chk(!vpp && !vcc && !busy, "R10 both supplies off", {vcc, vpp}, 0);

    run_byte(15'h2AAA, 8'h5A, 2);          // re-power path after power-down
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule